// File: doc/BRIEF.md
# Tuner Synthesiser Control Slave

This block is the two-wire serial slave that holds the programming state of a frequency synthesiser in a tuner. It oversamples the bus clock and data lines with the system clock, finds start and stop conditions, and accepts an address byte that carries a fixed five-bit device code, two variable address bits and a read/write flag. In a write session the first bit of each data byte chooses what the byte is. A frequency byte pair loads a 15-bit divide ratio. A control byte pair sets the charge-pump and test bits and the port enables. Byte pairs may follow one another without a new address until a stop arrives.

In a read session the slave shifts out a status byte. The byte holds the power-on flag, the lock flag, three port input levels and a 3-bit converter code. The slave sends it again each time the master acknowledges. The power-on flag is set by reset or by a pulse on the power-on input. It is cleared only by the stop that ends a read. The bus-facing SDA output is an open-drain pull-down enable. All other pins are plain levels. No pin carries streamed data, so the block has no valid/ready handshake.

Top module: `tuner_i2c_slave`

## Requirements
- R1: The address byte is accepted (SDA pulled low in its acknowledge slot) only when its bits 7..3 are 11000 and its bits 2..1 equal `adr_sel` or equal 01; bit 0 = 1 selects read, 0 selects write. Any other address gets no acknowledge and the session is ignored.
- R2: In a write session every complete data byte is acknowledged.
- R3: A first byte whose bit 7 is 0 stages bits 6..0 as ratio bits 14..8. The following byte gives ratio bits 7..0. `div_ratio` changes only when that second byte completes.
- R4: A first byte whose bit 7 is 1 is the control byte. Bit 6 drives `cp_hi`, bit 5 drives `test_mode`, bit 4 drives `cp_off` and bit 0 drives `drv_off`. They take effect when the byte completes.
- R5: The byte after a control byte is the port byte. Bits 7,6,3,2,1,0 map to `port_en[5:0]`, where 1 turns a port on and 0 leaves it high impedance.
- R6: After one address, any number of byte pairs may follow. Each pair is classified again by the bit 7 of its first byte.
- R7: A byte cut short by a stop or start before its eighth bit leaves every register unchanged. A lone frequency byte followed by a stop also leaves `div_ratio` unchanged.
- R8: A read returns {POR, `lock_in`, `port_lvl[2:0]`, `adc_code[2:0]`}, MSB first. A fresh copy is sent after each master acknowledge, and sending stops after a master no-acknowledge.
- R9: A stop that ends a read session clears POR. A stop that ends a write session does not.
- R10: Reset or a `por_pulse` sets POR and clears `div_ratio`, the control bits and `port_en`. When `por_pulse` coincides with a read-ending stop, POR stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| adr_sel | input | 2 | Selected variable address bits |
| por_pulse | input | 1 | Power-on reset indication |
| lock_in | input | 1 | Phase-lock flag |
| port_lvl | input | 3 | Levels of three port inputs |
| adc_code | input | 3 | Converter code |
| div_ratio | output | 15 | Programmed divide ratio |
| cp_hi | output | 1 | High charge-pump current |
| test_mode | output | 1 | Comparator test routing |
| cp_off | output | 1 | Charge-pump disable |
| drv_off | output | 1 | Drive amplifier off |
| port_en | output | 6 | Port on/off states |

## Verification
Two functions can land in the same cycle on the power-on flag. One is the clear caused by a stop at the end of a read. The other is the set caused by `por_pulse`. The bench holds `por_pulse` high for several bit periods around such a stop, so the detected stop falls inside the pulse. It then reads the status again and expects the flag still set, with ports, ratio and control bits cleared. A later read-ending stop without the pulse must clear the flag, which shows that the clear path still works.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam logic [4:0] DEV_CODE  = 5'b11000;
  localparam logic [1:0] ALWAYS_MA = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } eng_st_t;

  typedef enum logic [1:0] {
    PH_FIRST, PH_FREQ_LO, PH_PORT
  } pair_ph_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import tuner_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] adr_sel,
  input  logic [7:0] status,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_byte,
  output logic       sess_go,
  output logic       por_clr
);
  eng_st_t    st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       addr_ph, rd, rd_sess, mack;
  logic       hit;

  assign hit = (sh[7:3] == DEV_CODE) && ((sh[2:1] == adr_sel) || (sh[2:1] == ALWAYS_MA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      addr_ph <= 1'b0; rd <= 1'b0; rd_sess <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; wr_stb <= 1'b0; wr_byte <= '0; sess_go <= 1'b0; por_clr <= 1'b0;
    end else begin
      wr_stb  <= 1'b0;
      sess_go <= 1'b0;
      por_clr <= 1'b0;
      if (stop_det) begin
        st <= ST_IDLE;
        sda_oe <= 1'b0;
        por_clr <= rd_sess;
        rd_sess <= 1'b0;
      end else if (start_det) begin
        st <= ST_RX;
        addr_ph <= 1'b1;
        cnt <= '0;
        sda_oe <= 1'b0;
        rd_sess <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (addr_ph) begin
                if (hit) begin
                  sda_oe <= 1'b1;
                  st <= ST_ACK;
                  rd <= sh[0];
                  rd_sess <= sh[0];
                  sess_go <= ~sh[0];
                  addr_ph <= 1'b0;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                wr_stb <= 1'b1;
                wr_byte <= sh;
                sda_oe <= 1'b1;
                st <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rd) begin
                tx <= {status[6:0], 1'b0};
                sda_oe <= ~status[7];
                cnt <= 4'd1;
                st <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                cnt <= '0;
                st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st <= ST_MACK;
              end else begin
                sda_oe <= ~tx[7];
                tx <= {tx[6:0], 1'b0};
                cnt <= cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                tx <= {status[6:0], 1'b0};
                sda_oe <= ~status[7];
                cnt <= 4'd1;
                st <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the POR clear strobe only ever follows a detected stop
  a_r9_clear_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    por_clr |-> $past(stop_det));
  // R7: a stop always returns the engine to idle with the line released
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe));
endmodule

// File: rtl/tuner_reg_file.sv
module tuner_reg_file
  import tuner_i2c_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_pulse,
  input  logic              wr_stb,
  input  logic [7:0]        wr_byte,
  input  logic              sess_go,
  input  logic              por_clr,
  output logic [DIV_W-1:0]  div_ratio,
  output logic              cp_hi,
  output logic              test_mode,
  output logic              cp_off,
  output logic              drv_off,
  output logic [PORT_W-1:0] port_en,
  output logic              por_flag
);
  localparam int HI_W = DIV_W - 8;

  pair_ph_t        ph;
  logic [HI_W-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_FIRST; stage <= '0; div_ratio <= '0;
      cp_hi <= 1'b0; test_mode <= 1'b0; cp_off <= 1'b0; drv_off <= 1'b0;
      port_en <= '0; por_flag <= 1'b1;
    end else if (por_pulse) begin
      ph <= PH_FIRST; stage <= '0; div_ratio <= '0;
      cp_hi <= 1'b0; test_mode <= 1'b0; cp_off <= 1'b0; drv_off <= 1'b0;
      port_en <= '0; por_flag <= 1'b1;
    end else begin
      if (por_clr) por_flag <= 1'b0;
      if (sess_go) begin
        ph <= PH_FIRST;
      end else if (wr_stb) begin
        case (ph)
          PH_FIRST: begin
            if (wr_byte[7]) begin
              cp_hi     <= wr_byte[6];
              test_mode <= wr_byte[5];
              cp_off    <= wr_byte[4];
              drv_off   <= wr_byte[0];
              ph        <= PH_PORT;
            end else begin
              stage <= wr_byte[HI_W-1:0];
              ph    <= PH_FREQ_LO;
            end
          end
          PH_FREQ_LO: begin
            div_ratio <= {stage, wr_byte};
            ph        <= PH_FIRST;
          end
          default: begin
            port_en <= {wr_byte[7:6], wr_byte[3:0]};
            ph      <= PH_FIRST;
          end
        endcase
      end
    end
  end

  // R10: a power-on pulse wins over any clear and empties the outputs
  a_r10_por_wins: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> (por_flag && port_en == '0 && div_ratio == '0));
  // R3: the ratio never moves without a completed byte
  a_r3_div_only_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !por_pulse) |=> $stable(div_ratio));
  // R5: the ports never move without a completed byte
  a_r5_port_only_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !por_pulse) |=> $stable(port_en));
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 15,
  parameter int PORT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [1:0]        adr_sel,
  input  logic              por_pulse,
  input  logic              lock_in,
  input  logic [2:0]        port_lvl,
  input  logic [2:0]        adc_code,
  output logic [DIV_W-1:0]  div_ratio,
  output logic              cp_hi,
  output logic              test_mode,
  output logic              cp_off,
  output logic              drv_off,
  output logic [PORT_W-1:0] port_en
);
  logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_stb, sess_go, por_clr, por_flag;
  logic [7:0] wr_byte, status;

  assign status = {por_flag, lock_in, port_lvl, adc_code};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .adr_sel(adr_sel), .status(status), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .sess_go(sess_go), .por_clr(por_clr)
  );

  tuner_reg_file #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .sess_go(sess_go), .por_clr(por_clr),
    .div_ratio(div_ratio), .cp_hi(cp_hi), .test_mode(test_mode),
    .cp_off(cp_off), .drv_off(drv_off), .port_en(port_en), .por_flag(por_flag)
  );
endmodule

// File: tb/tuner_i2c_slave_tb.sv
`timescale 1ns/1ps
module tuner_i2c_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] adr_sel = 2'b00;
  logic por_pulse = 1'b0, lock_in = 1'b0;
  logic [2:0] port_lvl = 3'b000, adc_code = 3'b000;
  logic sda_oe, cp_hi, test_mode, cp_off, drv_off;
  logic [14:0] div_ratio;
  logic [5:0] port_en;
  wire sda_bus = sda_m & ~sda_oe;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tuner_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .adr_sel(adr_sel), .por_pulse(por_pulse), .lock_in(lock_in),
    .port_lvl(port_lvl), .adc_code(adc_code), .div_ratio(div_ratio),
    .cp_hi(cp_hi), .test_mode(test_mode), .cp_off(cp_off), .drv_off(drv_off),
    .port_en(port_en)
  );

  // {adr_sel, ma, first byte, second byte, exp ack, exp ratio, exp {cp_hi,test_mode,cp_off,drv_off}, exp ports}
  localparam int NV = 6;
  localparam logic [45:0] VEC [0:NV-1] = '{
    {2'b00, 2'b00, 8'h12, 8'h34, 1'b1, 15'h1234, 4'h0, 6'h00},
    {2'b00, 2'b01, 8'h7F, 8'hFF, 1'b1, 15'h7FFF, 4'h0, 6'h00},
    {2'b10, 2'b10, 8'hC1, 8'hCF, 1'b1, 15'h7FFF, 4'h9, 6'h3F},
    {2'b10, 2'b11, 8'h00, 8'h00, 1'b0, 15'h7FFF, 4'h9, 6'h3F},
    {2'b11, 2'b11, 8'hB0, 8'h85, 1'b1, 15'h7FFF, 4'h6, 6'h25},
    {2'b11, 2'b01, 8'h00, 8'h01, 1'b1, 15'h0001, 4'h6, 6'h25}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 1'b0;
    end
    wq(Q); sda_m = ~give_ack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic chk_regs(input string req, input logic [14:0] d, input logic [3:0] c, input logic [5:0] p);
    chk({req, " ratio"}, 32'(div_ratio), 32'(d));
    chk({req, " control"}, 32'({cp_hi, test_mode, cp_off, drv_off}), 32'(c));
    chk({req, " ports"}, 32'(port_en), 32'(p));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] rb;
    wq(5); rst_n = 1'b1; wq(5);
    chk_regs("R10 reset", 15'h0, 4'h0, 6'h00);

    // vector table: one write session per entry
    for (int v = 0; v < NV; v++) begin
      logic [45:0] e;
      e = VEC[v];
      adr_sel = e[45:44];
      i2c_start;
      wr_byte({5'b11000, e[43:42], 1'b0}, ack);
      chk("R1 address ack", 32'(ack), 32'(e[25]));
      if (ack) begin
        wr_byte(e[41:34], ack); chk("R2 data ack", 32'(ack), 1);
        wr_byte(e[33:26], ack); chk("R2 data ack", 32'(ack), 1);
      end
      i2c_stop;
      chk_regs("R3 R4 R5 vector", e[24:10], e[9:6], e[5:0]);
    end

    // R6: several pairs under one address
    adr_sel = 2'b00;
    i2c_start;
    wr_byte(8'hC2, ack);
    wr_byte(8'h05, ack); wr_byte(8'h06, ack);
    wr_byte(8'h80, ack); wr_byte(8'h00, ack);
    wr_byte(8'h01, ack); wr_byte(8'h02, ack);
    chk("R2 last ack", 32'(ack), 1);
    i2c_stop;
    chk_regs("R6 stream", 15'h0102, 4'h0, 6'h00);

    // R7: low byte cut by stop; lone high byte; byte cut by repeated start
    i2c_start; wr_byte(8'hC2, ack); wr_byte(8'h03, ack); send_bits(8'hAA, 4); i2c_stop;
    chk("R7 cut low byte", 32'(div_ratio), 32'h0102);
    i2c_start; wr_byte(8'hC2, ack); wr_byte(8'h0A, ack); i2c_stop;
    chk("R7 lone high byte", 32'(div_ratio), 32'h0102);
    i2c_start; wr_byte(8'hC2, ack); send_bits(8'h0F, 5);
    i2c_start; wr_byte(8'hC2, ack); i2c_stop;
    chk("R7 cut by start", 32'(div_ratio), 32'h0102);

    // R4/R5/R7: control applies alone, cut port byte keeps ports
    i2c_start; wr_byte(8'hC2, ack); wr_byte(8'hC0, ack); wr_byte(8'h41, ack); i2c_stop;
    chk_regs("R5 port byte", 15'h0102, 4'h8, 6'h11);
    i2c_start; wr_byte(8'hC2, ack); wr_byte(8'hF1, ack); send_bits(8'h00, 3); i2c_stop;
    chk_regs("R7 cut port byte", 15'h0102, 4'hF, 6'h11);

    // R8/R9: reads
    lock_in = 1'b1; port_lvl = 3'b101; adc_code = 3'b011;
    i2c_start; wr_byte(8'hC3, ack); chk("R1 read ack", 32'(ack), 1);
    rd_byte(1'b1, rb); chk("R8 status", 32'(rb), 32'hEB);
    rd_byte(1'b0, rb); chk("R8 repeat status", 32'(rb), 32'hEB);
    i2c_stop;
    adc_code = 3'b110;
    i2c_start; wr_byte(8'hC3, ack); rd_byte(1'b0, rb); i2c_stop;
    chk("R9 por cleared", 32'(rb), 32'h6E);
    i2c_start; wr_byte(8'hC2, ack); wr_byte(8'h80, ack); wr_byte(8'h00, ack); i2c_stop;
    i2c_start; wr_byte(8'hC3, ack); rd_byte(1'b0, rb); i2c_stop;
    chk("R9 write stop keeps clear", 32'(rb), 32'h6E);

    // R10: power-on pulse, then collision with a read-ending stop
    i2c_start; wr_byte(8'hC2, ack); wr_byte(8'h81, ack); wr_byte(8'hFF, ack); i2c_stop;
    por_pulse = 1'b1; wq(1); por_pulse = 1'b0; wq(2);
    chk_regs("R10 por pulse", 15'h0, 4'h0, 6'h00);
    i2c_start; wr_byte(8'hC3, ack); rd_byte(1'b0, rb);
    chk("R10 por set", 32'(rb), 32'hEE);
    por_pulse = 1'b1; i2c_stop; wq(2*Q); por_pulse = 1'b0; wq(2);
    i2c_start; wr_byte(8'hC3, ack); rd_byte(1'b0, rb); i2c_stop;
    chk("R10 set wins over clear", 32'(rb), 32'hEE);
    i2c_start; wr_byte(8'hC3, ack); rd_byte(1'b0, rb); i2c_stop;
    chk("R9 clear after collision", 32'(rb), 32'h6E);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule